// File: doc/BRIEF.md
# Indirect-Address MDIO Management Engine

This block runs indirect-address management transactions to a PHY over a two-wire serial management link. A host loads a command word with a register address, a device type, a PHY address and an opcode, and pulses a write strobe. The engine sets its busy bit, serialises one complete frame on MDC/MDIO, and clears busy without help when the frame ends. Each register access takes two commands: an address frame that loads the PHY's internal address pointer, then a separate read or write frame to the same PHY and device.

A single 16-bit data register serves both directions. The host loads it before a write command, and the engine sends its contents in the data field. After a read command the engine fills the register with the word sampled from the PHY, and it is valid once busy drops. MDC comes from the system clock through a parameterised divider. The pad is not part of the block: the design drives a separate output and output enable, and takes a separate input.

Top module: `mdio_cmd_engine`

## Requirements
- R1: After reset, busy is 0, MDC is 0, the MDIO output enable is 0 and the data register reads 0.
- R2: A command strobe with opcode 00 (address), 01 (write) or 11 (read) while busy is 0 sets busy. Busy clears by itself exactly FRAME_LEN*2*CLK_HALF system cycles later, where FRAME_LEN = PREAMBLE_LEN+32.
- R3: Each frame is sent MSB first, one bit per MDC period. It contains PREAMBLE_LEN ones, then the start code 00, the 2-bit opcode, the 5-bit PHY address, the 5-bit device type, a 2-bit turnaround and a 16-bit field. The whole frame is 64 MDC periods with the default parameters.
- R4: In an address frame the 16-bit field is the command's register address, and the turnaround is driven as 1 then 0.
- R5: In a write frame the 16-bit field is the data register, and the turnaround is driven as 1 then 0.
- R6: In a read frame the output enable is 1 through the device-type bits and 0 for the two turnaround bits and all 16 data bits. Data is sampled on MDC rising edges, MSB first, and written into the data register as busy clears.
- R7: MDC has a period of 2*CLK_HALF system cycles while busy and stays low while idle. The MDIO output changes only when MDC falls.
- R8: A command strobe while busy is ignored: the frame in progress is neither changed nor extended, and no second frame follows.
- R9: A data-register write while busy is ignored. The frame in flight and the register keep the earlier value.
- R10: A command strobe with the reserved opcode 10 is ignored: busy stays 0 and MDC stays low.
- R11: Address and write frames leave the data register unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd_op | input | 2 | Opcode: 00 address, 01 write, 11 read, 10 reserved |
| cmd_phy | input | 5 | Target PHY address |
| cmd_dev | input | 5 | Target device type |
| cmd_reg | input | 16 | Register address sent in an address frame |
| data_wr | input | 1 | Data register write strobe |
| data_wdata | input | 16 | Value loaded into the data register |
| busy | output | 1 | Command bit: set while a frame is in progress |
| data_q | output | 16 | Data register contents |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Serial data output enable |
| mdio_i | input | 1 | Serial data in |

## Verification
A stuck or misaligned bit counter shows up directly on the wire. A captured frame then has the wrong preamble length, a shifted field, or the wrong number of MDC rising edges within one busy window. Each of these is visible by the end of that frame. A wrong turnaround decision shows as the output enable staying high into the read field, or dropping during a write. A capture register that shifts on the wrong edge or in the wrong direction gives a data register value after the read that differs from the word the PHY model sent. A busy bit that fails to clear, or clears early, changes the measured busy width of the very first command.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

   typedef enum logic [1:0] {
      MOP_ADDR  = 2'b00,
      MOP_WRITE = 2'b01,
      MOP_RSVD  = 2'b10,
      MOP_READ  = 2'b11
   } mdio_op_e;

   localparam logic [1:0] START_CODE = 2'b00;
   localparam logic [1:0] TA_DRIVEN  = 2'b10;

   function automatic logic op_is_legal(input logic [1:0] op);
      return op != MOP_RSVD;
   endfunction

endpackage

// File: rtl/mdio_mdc_gen.sv
module mdio_mdc_gen #(
   parameter int CLK_HALF = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);

   logic mdc_q;
   logic wrap;

   generate
      if (CLK_HALF < 1) begin : g_bad_half
         $error("CLK_HALF must be at least 1");
      end

      if (CLK_HALF == 1) begin : g_toggle
         assign wrap = run;
      end else begin : g_count
         localparam int CW = $clog2(CLK_HALF);
         localparam logic [CW-1:0] LAST = CW'(CLK_HALF - 1);
         logic [CW-1:0] cnt_q;

         always_ff @(posedge clk) begin
            if (!rst_n || !run) begin
               cnt_q <= '0;
            end else if (cnt_q == LAST) begin
               cnt_q <= '0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end

         assign wrap = run && (cnt_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n || !run) begin
         mdc_q <= 1'b0;
      end else if (wrap) begin
         mdc_q <= ~mdc_q;
      end
   end

   assign mdc      = mdc_q;
   assign rise_stb = wrap && !mdc_q;
   assign fall_stb = wrap && mdc_q;

endmodule

// File: rtl/mdio_frame_ser.sv
module mdio_frame_ser #(
   parameter int FRAME_LEN = 64,
   parameter int FIELD_W   = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [FRAME_LEN-1:0] frame,
   input  logic                 is_read,
   input  logic                 rise_stb,
   input  logic                 fall_stb,
   input  logic                 mdio_i,
   output logic                 active,
   output logic                 done,
   output logic                 mdio_o,
   output logic                 mdio_oe,
   output logic [FIELD_W-1:0]   rd_word
);

   localparam int BW = $clog2(FRAME_LEN);
   localparam logic [BW-1:0] LAST_BIT = BW'(FRAME_LEN - 1);
   localparam logic [BW-1:0] TA_BIT   = BW'(FRAME_LEN - FIELD_W - 2);
   localparam logic [BW-1:0] FLD_BIT  = BW'(FRAME_LEN - FIELD_W);

   generate
      if (FRAME_LEN < FIELD_W + 4) begin : g_bad_len
         $error("FRAME_LEN too short for field and turnaround");
      end
   endgenerate

   logic [FRAME_LEN-1:0] sh_q;
   logic [BW-1:0]        bit_q;
   logic                 act_q;
   logic                 rd_q;
   logic [FIELD_W-1:0]   cap_q;
   logic                 last_fall;

   assign last_fall = act_q && fall_stb && (bit_q == LAST_BIT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q  <= '0;
         bit_q <= '0;
         act_q <= 1'b0;
         rd_q  <= 1'b0;
      end else if (start && !act_q) begin
         sh_q  <= frame;
         bit_q <= '0;
         act_q <= 1'b1;
         rd_q  <= is_read;
      end else if (act_q && fall_stb) begin
         if (bit_q == LAST_BIT) begin
            act_q <= 1'b0;
         end else begin
            sh_q  <= {sh_q[FRAME_LEN-2:0], 1'b0};
            bit_q <= bit_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cap_q <= '0;
      end else if (start && !act_q) begin
         cap_q <= '0;
      end else if (act_q && rd_q && rise_stb && (bit_q >= FLD_BIT)) begin
         cap_q <= {cap_q[FIELD_W-2:0], mdio_i};
      end
   end

   assign active  = act_q;
   assign done    = last_fall;
   assign mdio_o  = act_q ? sh_q[FRAME_LEN-1] : 1'b0;
   assign mdio_oe = act_q && !(rd_q && (bit_q >= TA_BIT));
   assign rd_word = cap_q;

endmodule

// File: rtl/mdio_cmd_engine.sv
module mdio_cmd_engine
   import mdio_pkg::*;
#(
   parameter int CLK_HALF     = 2,
   parameter int PREAMBLE_LEN = 32,
   parameter int PHY_W        = 5,
   parameter int DEV_W        = 5,
   parameter int FIELD_W      = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_wr,
   input  logic [1:0]         cmd_op,
   input  logic [PHY_W-1:0]   cmd_phy,
   input  logic [DEV_W-1:0]   cmd_dev,
   input  logic [FIELD_W-1:0] cmd_reg,
   input  logic               data_wr,
   input  logic [FIELD_W-1:0] data_wdata,
   output logic               busy,
   output logic [FIELD_W-1:0] data_q,
   output logic               mdc,
   output logic               mdio_o,
   output logic               mdio_oe,
   input  logic               mdio_i
);

   localparam int FRAME_LEN = PREAMBLE_LEN + 2 + 2 + PHY_W + DEV_W + 2 + FIELD_W;

   generate
      if (PREAMBLE_LEN < 1 || PREAMBLE_LEN > 32) begin : g_bad_pre
         $error("PREAMBLE_LEN must be 1..32");
      end
      if (PHY_W != 5 || DEV_W != 5 || FIELD_W != 16) begin : g_bad_fmt
         $error("frame field widths are fixed by the protocol");
      end
   endgenerate

   logic                 busy_q;
   logic [FIELD_W-1:0]   data_r;
   logic                 accept;
   logic                 is_read;
   logic [FIELD_W-1:0]   field;
   logic [FRAME_LEN-1:0] frame;
   logic                 ser_active;
   logic                 ser_done;
   logic [FIELD_W-1:0]   ser_word;
   logic                 rise_stb;
   logic                 fall_stb;
   logic                 last_read_q;

   assign accept  = cmd_wr && !busy_q && op_is_legal(cmd_op);
   assign is_read = (cmd_op == MOP_READ);
   assign field   = (cmd_op == MOP_ADDR) ? cmd_reg : data_r;
   assign frame   = {{PREAMBLE_LEN{1'b1}}, START_CODE, cmd_op, cmd_phy, cmd_dev,
                     TA_DRIVEN, field};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q      <= 1'b0;
         last_read_q <= 1'b0;
      end else if (accept) begin
         busy_q      <= 1'b1;
         last_read_q <= is_read;
      end else if (ser_done) begin
         busy_q      <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         data_r <= '0;
      end else if (ser_done && last_read_q) begin
         data_r <= ser_word;
      end else if (data_wr && !busy_q) begin
         data_r <= data_wdata;
      end
   end

   mdio_mdc_gen #(
      .CLK_HALF (CLK_HALF)
   ) u_mdc (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (ser_active),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_frame_ser #(
      .FRAME_LEN (FRAME_LEN),
      .FIELD_W   (FIELD_W)
   ) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (accept),
      .frame    (frame),
      .is_read  (is_read),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb),
      .mdio_i   (mdio_i),
      .active   (ser_active),
      .done     (ser_done),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_word  (ser_word)
   );

   assign busy   = busy_q;
   assign data_q = data_r;

endmodule

// File: rtl/mdio_cmd_engine_chk.sv
module mdio_cmd_engine_chk #(
   parameter int CLK_HALF     = 2,
   parameter int PREAMBLE_LEN = 32,
   parameter int FIELD_W      = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               cmd_wr,
   input logic [1:0]         cmd_op,
   input logic               busy,
   input logic [FIELD_W-1:0] data_q,
   input logic               mdc,
   input logic               mdio_o,
   input logic               mdio_oe
);

   localparam int BUSY_MAX = (PREAMBLE_LEN + 32) * 2 * CLK_HALF;
   localparam int LW = $clog2(BUSY_MAX + 2);

   logic [LW-1:0] busy_len;

   always_ff @(posedge clk) begin
      if (!rst_n || !busy) begin
         busy_len <= '0;
      end else if (busy_len <= LW'(BUSY_MAX)) begin
         busy_len <= busy_len + 1'b1;
      end
   end

   assert_busy_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (busy_len < LW'(BUSY_MAX)));

   assert_oe_in_frame_R6: assert property (@(posedge clk) disable iff (!rst_n)
      mdio_oe |-> busy);

   assert_mdc_idle_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !mdc);

   assert_mdio_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mdio_oe && $past(mdio_oe) && !$stable(mdio_o)) |-> $fell(mdc));

   assert_data_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> (!busy || $stable(data_q)));

   assert_rsvd_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && cmd_wr && cmd_op == 2'b10) |=> !busy);

endmodule

bind mdio_cmd_engine mdio_cmd_engine_chk #(
   .CLK_HALF     (CLK_HALF),
   .PREAMBLE_LEN (PREAMBLE_LEN),
   .FIELD_W      (FIELD_W)
) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .cmd_wr  (cmd_wr),
   .cmd_op  (cmd_op),
   .busy    (busy),
   .data_q  (data_q),
   .mdc     (mdc),
   .mdio_o  (mdio_o),
   .mdio_oe (mdio_oe)
);

// File: tb/sim_mdio_cmd_engine.sv
module sim_mdio_cmd_engine;

   localparam int HALF  = 2;
   localparam int FLEN  = 64;
   localparam int BUSYC = FLEN * 2 * HALF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_wr = 1'b0;
   logic [1:0]  cmd_op = 2'b00;
   logic [4:0]  cmd_phy = '0;
   logic [4:0]  cmd_dev = '0;
   logic [15:0] cmd_reg = '0;
   logic        data_wr = 1'b0;
   logic [15:0] data_wdata = '0;
   logic        busy;
   logic [15:0] data_q;
   logic        mdc;
   logic        mdio_o;
   logic        mdio_oe;
   logic        mdio_i = 1'b1;

   int errors = 0;
   int checks = 0;
   int cyc = 0;

   // PHY-side observer state
   logic [63:0] cap_o;
   logic [63:0] cap_oe;
   int          n_rise;
   logic [15:0] resp = '0;
   logic        mdc_prev = 1'b0;
   int          last_rise = -1;
   int          bad_period = 0;

   always #4 clk = ~clk;

   mdio_cmd_engine #(.CLK_HALF(HALF), .PREAMBLE_LEN(32)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_op(cmd_op),
      .cmd_phy(cmd_phy), .cmd_dev(cmd_dev), .cmd_reg(cmd_reg),
      .data_wr(data_wr), .data_wdata(data_wdata), .busy(busy),
      .data_q(data_q), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   always @(negedge clk) begin
      cyc <= cyc + 1;
      if (mdc && !mdc_prev) begin
         cap_o  = {cap_o[62:0], mdio_o};
         cap_oe = {cap_oe[62:0], mdio_oe};
         if (n_rise > 0 && (cyc - last_rise) != 2 * HALF) bad_period++;
         last_rise = cyc;
         n_rise++;
      end
      if (!mdc && mdc_prev) begin
         if (n_rise >= 48 && n_rise < 64) mdio_i = resp[63 - n_rise];
         else mdio_i = 1'b1;
      end
      mdc_prev = mdc;
   end

   always @(negedge clk) begin
      if (cyc > 150000) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_obs();
      cap_o = '0; cap_oe = '0; n_rise = 0; bad_period = 0;
   endtask

   task automatic issue(input logic [1:0] op, input logic [4:0] phy,
                        input logic [4:0] dev, input logic [15:0] rg);
      @(negedge clk);
      cmd_wr = 1'b1; cmd_op = op; cmd_phy = phy; cmd_dev = dev; cmd_reg = rg;
      @(negedge clk);
      cmd_wr = 1'b0;
   endtask

   task automatic load_data(input logic [15:0] v);
      @(negedge clk);
      data_wr = 1'b1; data_wdata = v;
      @(negedge clk);
      data_wr = 1'b0;
   endtask

   task automatic wait_idle(output int n);
      n = 0;
      while (busy && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   function automatic logic [63:0] exp_frame(input logic [1:0] op, input logic [4:0] phy,
                                             input logic [4:0] dev, input logic [15:0] f);
      return {32'hFFFF_FFFF, 2'b00, op, phy, dev, 2'b10, f};
   endfunction

   task automatic t_reset();
      check("R1 busy", 64'(busy), 64'd0);
      check("R1 mdc", 64'(mdc), 64'd0);
      check("R1 oe", 64'(mdio_oe), 64'd0);
      check("R1 data", 64'(data_q), 64'd0);
   endtask

   task automatic t_addr();
      int n;
      clear_obs();
      issue(2'b00, 5'h03, 5'h01, 16'hC35A);
      wait_idle(n);
      check("R2 busy width addr", 64'(n), 64'(BUSYC));
      check("R3 rise count", 64'(n_rise), 64'd64);
      check("R4 addr frame", cap_o, exp_frame(2'b00, 5'h03, 5'h01, 16'hC35A));
      check("R4 oe held", cap_oe, {64{1'b1}});
      check("R7 mdc period", 64'(bad_period), 64'd0);
      check("R11 data after addr", 64'(data_q), 64'd0);
   endtask

   task automatic t_write();
      int n;
      load_data(16'h9E21);
      clear_obs();
      issue(2'b01, 5'h1F, 5'h1E, 16'h0000);
      wait_idle(n);
      check("R5 write frame", cap_o, exp_frame(2'b01, 5'h1F, 5'h1E, 16'h9E21));
      check("R5 oe held", cap_oe, {64{1'b1}});
      check("R11 data after write", 64'(data_q), 64'h9E21);
   endtask

   task automatic t_read(input logic [15:0] word, input logic [4:0] phy);
      int n;
      resp = word;
      clear_obs();
      issue(2'b11, phy, 5'h05, 16'h0000);
      wait_idle(n);
      check("R2 busy width read", 64'(n), 64'(BUSYC));
      check("R6 read header", {18'd0, cap_o[63:18]},
            {18'd0, exp_frame(2'b11, phy, 5'h05, 16'h0) >> 18});
      check("R6 oe released", cap_oe, {{46{1'b1}}, 18'd0});
      check("R6 read data", 64'(data_q), 64'(word));
   endtask

   task automatic t_busy_cmd();
      int n;
      clear_obs();
      issue(2'b00, 5'h0A, 5'h02, 16'h1234);
      repeat (20) @(negedge clk);
      issue(2'b01, 5'h15, 5'h07, 16'hFFFF);
      wait_idle(n);
      check("R8 frame unchanged", cap_o, exp_frame(2'b00, 5'h0A, 5'h02, 16'h1234));
      check("R8 not extended", 64'(n + 22), 64'(BUSYC));
      repeat (4) @(negedge clk);
      check("R8 no second frame", {63'd0, busy}, 64'd0);
      check("R8 no extra mdc", 64'(n_rise), 64'd64);
   endtask

   task automatic t_busy_data();
      int n;
      load_data(16'h5AA5);
      clear_obs();
      issue(2'b01, 5'h01, 5'h03, 16'h0);
      repeat (10) @(negedge clk);
      load_data(16'h0FF0);
      wait_idle(n);
      check("R9 frame keeps data", cap_o, exp_frame(2'b01, 5'h01, 5'h03, 16'h5AA5));
      check("R9 register kept", 64'(data_q), 64'h5AA5);
   endtask

   task automatic t_rsvd();
      clear_obs();
      issue(2'b10, 5'h01, 5'h01, 16'h1);
      repeat (12) @(negedge clk);
      check("R10 busy stays low", 64'(busy), 64'd0);
      check("R10 no mdc", 64'(n_rise), 64'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_addr();
      t_write();
      t_read(16'hA5C3, 5'h02);
      t_read(16'h8001, 5'h11);
      t_busy_cmd();
      t_busy_data();
      t_rsvd();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule